// File: doc/BRIEF.md
# Two-Port Mailbox Interrupt Flags

This block produces the pair of cross-port interrupt flags for a memory shared by a left port and a right port. The two highest word addresses serve as mailboxes, one per direction. The all-ones address carries messages from left to right. The all-ones-minus-one address carries messages from right to left. Posting into a mailbox raises the receiving port's active-low interrupt. Reading that mailbox from the receiving side withdraws it. The message word is ordinary memory content held by the array outside this block. The block only observes each port's enable, read/write, output enable, address and busy status, and keeps one flag per direction.

Each flag is a two-state machine with the states FLAG_IDLE (flag high) and FLAG_PENDING (flag low). There are three named transitions. POST moves the machine from FLAG_IDLE to FLAG_PENDING. ACK moves it from FLAG_PENDING back to FLAG_IDLE. REPOST keeps FLAG_PENDING when a post and an acknowledge arrive together. Accesses are sampled on the rising clock edge, so a flag changes in the cycle after the access. If software never uses the mailboxes, it can treat the two top words as normal memory, because the flags have no effect on the data.

Top module: `mbx_irq`

## Requirements
- R1: While reset (rst_n low) is active, and after reset until a post happens, both l_irq_n and r_irq_n are 1.
- R2: A left write (l_en_n=0, l_rw_n=0) to the all-ones address with l_busy_n=1 drives r_irq_n to 0 from the next rising edge.
- R3: A right read (r_en_n=0, r_oe_n=0, r_rw_n ignored) of the all-ones address with r_busy_n=1 returns r_irq_n to 1 from the next rising edge, unless R7 applies.
- R4: A right write (r_en_n=0, r_rw_n=0) to the all-ones-minus-one address with r_busy_n=1 drives l_irq_n to 0 from the next rising edge.
- R5: A left read (l_en_n=0, l_oe_n=0) of the all-ones-minus-one address with l_busy_n=1 returns l_irq_n to 1 from the next rising edge, unless R7 applies.
- R6: When the busy input of the port making a post or acknowledge access is 0, that access leaves the flag unchanged.
- R7: When a post and an acknowledge of the same flag happen in the same cycle, the flag is 0 after the edge.
- R8: Any other access leaves both flags unchanged. This covers other addresses, a deselected port, a write by the receiving port, and a read by the posting port.
- R9: The address width is a parameter. With ADDR_W=12 the mailboxes are 0xFFF (left to right) and 0xFFE (right to left), and 0xFFD posts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, accesses sampled on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_en_n | input | 1 | Left port enable, active low |
| l_rw_n | input | 1 | Left read/write, 0 = write |
| l_oe_n | input | 1 | Left output enable, active low |
| l_addr | input | ADDR_W | Left word address |
| l_busy_n | input | 1 | Left busy status, 0 blocks left posts and acknowledges |
| r_en_n | input | 1 | Right port enable, active low |
| r_rw_n | input | 1 | Right read/write, 0 = write |
| r_oe_n | input | 1 | Right output enable, active low |
| r_addr | input | ADDR_W | Right word address |
| r_busy_n | input | 1 | Right busy status, 0 blocks right posts and acknowledges |
| l_irq_n | output | 1 | Interrupt to the left port, active low |
| r_irq_n | output | 1 | Interrupt to the right port, active low |

## Verification
Two events can reach the same flag in one clock: a post from one port and an acknowledge from the other. The bench causes this by sweeping both ports together over four addresses, including both mailboxes, and over every enable, read/write, output-enable and busy combination. Each sweep point starts from each of the four flag starting states. The expected flag after every access is computed arithmetically. A cycle that holds both a post and an acknowledge must end with the flag low, whatever state it started in.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    // Per-direction flag machine
    typedef enum logic {
        FLAG_IDLE    = 1'b0,
        FLAG_PENDING = 1'b1
    } flag_state_e;

    // Number of ports sharing the memory
    localparam int unsigned NUM_PORTS = 2;

    // Index of the opposite port
    function automatic int unsigned peer_of(input int unsigned p);
        return (p == 0) ? 1 : 0;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
    parameter int unsigned ADDR_W    = 13,
    parameter logic [ADDR_W-1:0] SEND_ADDR = '1,
    parameter logic [ADDR_W-1:0] RECV_ADDR = '0
) (
    input  logic              en_n,
    input  logic              rw_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy_n,
    output logic              post,
    output logic              ack
);

    logic selected;
    logic wr_cycle;
    logic rd_cycle;

    always_comb begin
        selected = ~en_n & busy_n;
        wr_cycle = selected & ~rw_n;
        rd_cycle = selected & ~oe_n;
        post     = wr_cycle & (addr == SEND_ADDR);
        ack      = rd_cycle & (addr == RECV_ADDR);
    end

endmodule

// File: rtl/mbx_flag_fsm.sv
module mbx_flag_fsm
    import mbx_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic post,
    input  logic ack,
    output logic irq_n
);

    flag_state_e state_q;
    flag_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FLAG_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: POST, ACK, REPOST (post beats ack)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FLAG_IDLE: begin
                if (post) begin
                    state_d = FLAG_PENDING;
                end
            end
            FLAG_PENDING: begin
                if (ack && !post) begin
                    state_d = FLAG_IDLE;
                end
            end
            default: state_d = FLAG_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        irq_n = (state_q != FLAG_PENDING);
    end

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
    import mbx_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              l_en_n,
    input  logic              l_rw_n,
    input  logic              l_oe_n,
    input  logic [ADDR_W-1:0] l_addr,
    input  logic              l_busy_n,
    input  logic              r_en_n,
    input  logic              r_rw_n,
    input  logic              r_oe_n,
    input  logic [ADDR_W-1:0] r_addr,
    input  logic              r_busy_n,
    output logic              l_irq_n,
    output logic              r_irq_n
);

    // Mailbox 0 (all ones): left -> right; mailbox 1 (all ones - 1): right -> left
    localparam logic [ADDR_W-1:0] MBX_HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] MBX_LO = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic [NUM_PORTS-1:0]             en_n_v, rw_n_v, oe_n_v, busy_n_v;
    logic [NUM_PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [NUM_PORTS-1:0]             post_v, ack_v, irq_n_v;

    always_comb begin
        en_n_v   = {r_en_n,   l_en_n};
        rw_n_v   = {r_rw_n,   l_rw_n};
        oe_n_v   = {r_oe_n,   l_oe_n};
        busy_n_v = {r_busy_n, l_busy_n};
        addr_v   = {r_addr,   l_addr};
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        localparam logic [ADDR_W-1:0] SEND = (p == 0) ? MBX_HI : MBX_LO;
        localparam logic [ADDR_W-1:0] RECV = (p == 0) ? MBX_LO : MBX_HI;

        mbx_port_decode #(
            .ADDR_W   (ADDR_W),
            .SEND_ADDR(SEND),
            .RECV_ADDR(RECV)
        ) u_dec (
            .en_n  (en_n_v[p]),
            .rw_n  (rw_n_v[p]),
            .oe_n  (oe_n_v[p]),
            .addr  (addr_v[p]),
            .busy_n(busy_n_v[p]),
            .post  (post_v[p]),
            .ack   (ack_v[p])
        );

        // Flag p is raised by the peer and acknowledged by port p
        mbx_flag_fsm u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .post (post_v[peer_of(p)]),
            .ack  (ack_v[p]),
            .irq_n(irq_n_v[p])
        );
    end

    always_comb begin
        l_irq_n = irq_n_v[0];
        r_irq_n = irq_n_v[1];
    end

endmodule

// File: rtl/mbx_irq_chk.sv
module mbx_irq_chk #(
    parameter int unsigned ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              l_en_n,
    input logic              l_rw_n,
    input logic              l_oe_n,
    input logic [ADDR_W-1:0] l_addr,
    input logic              l_busy_n,
    input logic              r_en_n,
    input logic              r_rw_n,
    input logic              r_oe_n,
    input logic [ADDR_W-1:0] r_addr,
    input logic              r_busy_n,
    input logic              l_irq_n,
    input logic              r_irq_n
);

    localparam logic [ADDR_W-1:0] HI = {ADDR_W{1'b1}};
    localparam logic [ADDR_W-1:0] LO = {{(ADDR_W-1){1'b1}}, 1'b0};

    logic try_set_r, try_clr_r, try_set_l, try_clr_l;
    logic set_r, clr_r, set_l, clr_l;

    assign try_set_r = !l_en_n && !l_rw_n && (l_addr == HI);
    assign try_clr_r = !r_en_n && !r_oe_n && (r_addr == HI);
    assign try_set_l = !r_en_n && !r_rw_n && (r_addr == LO);
    assign try_clr_l = !l_en_n && !l_oe_n && (l_addr == LO);
    assign set_r = try_set_r && l_busy_n;
    assign clr_r = try_clr_r && r_busy_n;
    assign set_l = try_set_l && r_busy_n;
    assign clr_l = try_clr_l && l_busy_n;

    AST_RESET_IDLE: assert property (@(posedge clk) $rose(rst_n) |-> (l_irq_n && r_irq_n)); // R1
    AST_SET_RIGHT:  assert property (@(posedge clk) disable iff (!rst_n) set_r |=> !r_irq_n); // R2
    AST_CLR_RIGHT:  assert property (@(posedge clk) disable iff (!rst_n) (clr_r && !set_r) |=> r_irq_n); // R3
    AST_SET_LEFT:   assert property (@(posedge clk) disable iff (!rst_n) set_l |=> !l_irq_n); // R4
    AST_CLR_LEFT:   assert property (@(posedge clk) disable iff (!rst_n) (clr_l && !set_l) |=> l_irq_n); // R5
    AST_BUSY_BLOCK: assert property (@(posedge clk) disable iff (!rst_n) (try_set_r && !l_busy_n && !clr_r) |=> $stable(r_irq_n)); // R6
    AST_POST_WINS:  assert property (@(posedge clk) disable iff (!rst_n) (set_l && clr_l) |=> !l_irq_n); // R7
    AST_HOLD_RIGHT: assert property (@(posedge clk) disable iff (!rst_n) (!set_r && !clr_r) |=> $stable(r_irq_n)); // R8
    AST_HOLD_LEFT:  assert property (@(posedge clk) disable iff (!rst_n) (!set_l && !clr_l) |=> $stable(l_irq_n)); // R8

endmodule

bind mbx_irq mbx_irq_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/mbx_irq_tb.sv
module mbx_irq_tb;

    localparam int CLK_PERIOD = 10;
    localparam int AW  = 4;
    localparam int AW2 = 12;
    localparam logic [AW-1:0] HI = {AW{1'b1}};
    localparam logic [AW-1:0] LO = HI - 1'b1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic l_en_n = 1, l_rw_n = 1, l_oe_n = 1, l_busy_n = 1;
    logic r_en_n = 1, r_rw_n = 1, r_oe_n = 1, r_busy_n = 1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    logic w_l_en_n = 1, w_l_rw_n = 1, w_l_oe_n = 1;
    logic w_r_en_n = 1, w_r_rw_n = 1, w_r_oe_n = 1;
    logic [AW2-1:0] w_l_addr = '0, w_r_addr = '0;
    logic w_l_irq_n, w_r_irq_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mbx_irq #(.ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(l_en_n), .l_rw_n(l_rw_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_en_n(r_en_n), .r_rw_n(r_rw_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    mbx_irq #(.ADDR_W(AW2)) u_dut_w12 (
        .clk(clk), .rst_n(rst_n),
        .l_en_n(w_l_en_n), .l_rw_n(w_l_rw_n), .l_oe_n(w_l_oe_n), .l_addr(w_l_addr), .l_busy_n(1'b1),
        .r_en_n(w_r_en_n), .r_rw_n(w_r_rw_n), .r_oe_n(w_r_oe_n), .r_addr(w_r_addr), .r_busy_n(1'b1),
        .l_irq_n(w_l_irq_n), .r_irq_n(w_r_irq_n)
    );

    task automatic check(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // ctrl bits: [3]=en_n [2]=rw_n [1]=oe_n [0]=busy_n
    task automatic drive(input logic [3:0] lc, input logic [AW-1:0] la,
                         input logic [3:0] rc, input logic [AW-1:0] ra);
        {l_en_n, l_rw_n, l_oe_n, l_busy_n} = lc;
        {r_en_n, r_rw_n, r_oe_n, r_busy_n} = rc;
        l_addr = la;
        r_addr = ra;
        @(negedge clk);
    endtask

    localparam logic [3:0] IDLE  = 4'b1111;
    localparam logic [3:0] WRITE = 4'b0011;
    localparam logic [3:0] READ  = 4'b0101;

    function automatic logic [AW-1:0] pick(input int i);
        case (i)
            0: return HI;
            1: return LO;
            2: return '0;
            default: return 4'd6;
        endcase
    endfunction

    function automatic string tag_of(input logic s, input logic c, input logic bs, input logic bc);
        if (s && c) return "R7";
        if (s) return "R2/R4";
        if (c) return "R3/R5";
        if (bs || bc) return "R6";
        return "R8";
    endfunction

    task automatic w12(input logic [2:0] lc, input logic [AW2-1:0] la,
                       input logic [2:0] rc, input logic [AW2-1:0] ra);
        {w_l_en_n, w_l_rw_n, w_l_oe_n} = lc;
        {w_r_en_n, w_r_rw_n, w_r_oe_n} = rc;
        w_l_addr = la;
        w_r_addr = ra;
        @(negedge clk);
        {w_l_en_n, w_l_rw_n, w_l_oe_n, w_r_en_n, w_r_rw_n, w_r_oe_n} = 6'b111111;
    endtask

    initial begin
        #(CLK_PERIOD * 190000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1", "l_irq_n in reset", l_irq_n, 1'b1);
        check("R1", "r_irq_n in reset", r_irq_n, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", "l_irq_n after reset", l_irq_n, 1'b1);
        check("R1", "r_irq_n after reset", r_irq_n, 1'b1);

        // Joint sweep of both ports from every starting flag state
        for (int init = 0; init < 4; init++) begin
            for (int li = 0; li < 4; li++) begin
                for (int ri = 0; ri < 4; ri++) begin
                    for (int lc = 0; lc < 16; lc++) begin
                        for (int rc = 0; rc < 16; rc++) begin
                            logic want_r, want_l;
                            logic [AW-1:0] la, ra;
                            logic tsr, tcr, tsl, tcl, sr, cr, sl, cl, er, el;
                            want_r = init[0];
                            want_l = init[1];
                            if (want_r) drive(WRITE, HI, IDLE, '0);
                            else        drive(IDLE, '0, READ, HI);
                            if (want_l) drive(IDLE, '0, WRITE, LO);
                            else        drive(READ, LO, IDLE, '0);
                            la = pick(li);
                            ra = pick(ri);
                            drive(4'(lc), la, 4'(rc), ra);
                            tsr = !lc[3] && !lc[2] && la == HI;
                            tcr = !rc[3] && !rc[1] && ra == HI;
                            tsl = !rc[3] && !rc[2] && ra == LO;
                            tcl = !lc[3] && !lc[1] && la == LO;
                            sr = tsr && lc[0];
                            cr = tcr && rc[0];
                            sl = tsl && rc[0];
                            cl = tcl && lc[0];
                            er = sr ? 1'b1 : (cr ? 1'b0 : want_r);
                            el = sl ? 1'b1 : (cl ? 1'b0 : want_l);
                            check(tag_of(sr, cr, tsr && !lc[0], tcr && !rc[0]), "r_irq_n sweep", r_irq_n, !er);
                            check(tag_of(sl, cl, tsl && !rc[0], tcl && !lc[0]), "l_irq_n sweep", l_irq_n, !el);
                            drive(IDLE, '0, IDLE, '0);
                        end
                    end
                end
            end
        end

        // R1: reset while flags are pending returns them high
        drive(WRITE, HI, WRITE, LO);
        drive(IDLE, '0, IDLE, '0);
        rst_n = 1'b0;
        #1;
        check("R1", "l_irq_n async reset", l_irq_n, 1'b1);
        check("R1", "r_irq_n async reset", r_irq_n, 1'b1);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: 12-bit configuration mailboxes
        w12(3'b001, 12'hFFD, 3'b111, '0);
        check("R9", "w12 r_irq_n after write FFD", w_r_irq_n, 1'b1);
        w12(3'b001, 12'hFFF, 3'b111, '0);
        check("R9", "w12 r_irq_n after write FFF", w_r_irq_n, 1'b0);
        w12(3'b111, '0, 3'b010, 12'hFFF);
        check("R9", "w12 r_irq_n after read FFF", w_r_irq_n, 1'b1);
        w12(3'b111, '0, 3'b001, 12'hFFE);
        check("R9", "w12 l_irq_n after write FFE", w_l_irq_n, 1'b0);
        w12(3'b010, 12'hFFE, 3'b111, '0);
        check("R9", "w12 l_irq_n after read FFE", w_l_irq_n, 1'b1);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule